// File: doc/BRIEF.md
# GPIO Edge Interrupt Generator

This block watches a bank of general-purpose I/O pins and turns chosen signal edges into pulses. For each pin it raises a one-cycle CPU interrupt pulse and a matching one-cycle DMA synchronization pulse. Each pin can fire on a rising edge, on a falling edge, on both edges, or not at all. All edge detection runs on the peripheral clock.

The edge selection lives in two per-pin state vectors, one enabling rising edges and one enabling falling edges. Software cannot read or load these vectors directly. It changes them only through four write strobes that share one data word. Two of the strobes set bits in a vector and two clear bits in it. A data bit of 0 leaves the matching state bit unchanged.

The observed pin value is taken after the output-enable mux. For a pin that is driven as an output, the driven value is used directly. So when software toggles the output data of such a pin, the pin raises its own interrupt. External inputs pass through a synchronizer before their edges are detected.

Top module: `gpio_edge_irq`

## Requirements
- R1: While and after reset, `irq_pulse` and `dma_evt` are 0 and both edge-enable vectors are 0. Pin activity after reset produces no pulse until an enable bit has been set.
- R2: When `wr_stb[0]` (set rising) or `wr_stb[2]` (set falling) is high, every bit of `wr_data` that is 1 sets the matching bit of the rising or falling enable vector at that clock edge. Bits written as 0 leave the vector unchanged.
- R3: When `wr_stb[1]` (clear rising) or `wr_stb[3]` (clear falling) is high, every bit of `wr_data` that is 1 clears the matching bit of the rising or falling enable vector. Bits written as 0 leave the vector unchanged.
- R4: When the set strobe and the clear strobe of the same vector are both high in one cycle, every bit that has a 1 in `wr_data` ends cleared.
- R5: A pin whose rising enable and falling enable are both 0 never produces a pulse.
- R6: A pin with only its falling enable set pulses on a 1-to-0 change of its observed value, and never on a 0-to-1 change.
- R7: A pin with only its rising enable set pulses on a 0-to-1 change of its observed value, and never on a 1-to-0 change.
- R8: A pin with both enables set pulses on every change of its observed value.
- R9: For a pin with `out_en` at 0, the observed value is `pin_in` taken through a two-flop synchronizer. A change of `pin_in` that is set up before clock edge k shows its pulse in the cycle after edge k+2.
- R10: For a pin with `out_en` at 1, the observed value is `out_val`. A change of `out_val` that is set up before edge k shows its pulse in the cycle after edge k.
- R11: Each detected edge gives a pulse exactly one cycle wide. `irq_pulse` and `dma_evt` are equal in every cycle.
- R12: An enable write takes effect one cycle after its clock edge. An edge detected at the same clock edge as the write is judged with the old enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 4 | Write strobes: [0] set rising, [1] clear rising, [2] set falling, [3] clear falling |
| wr_data | input | NPINS | Bit mask applied by the active strobes |
| pin_in | input | NPINS | Raw external pin levels (asynchronous) |
| out_val | input | NPINS | Output data driven onto the pins |
| out_en | input | NPINS | Per-pin output enable; 1 selects `out_val` as the observed value |
| irq_pulse | output | NPINS | Per-pin CPU interrupt pulse |
| dma_evt | output | NPINS | Per-pin DMA synchronization event pulse |

## Verification
The hardest case to reach from the ports is a collision: an edge arriving at the same clock edge as a write to that pin's enable, or a set and a clear strobe landing on one bit together. Directed steps line up an `out_val` toggle with a set strobe at one edge, and raise both strobes of a vector at once. A long random phase then drives strobes, data, output enables and pin levels every cycle, so that switching `out_en` between differing pin and output values also produces edges. A cycle-by-cycle reference model in the bench predicts both pulse vectors throughout.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  // Position of each write strobe inside wr_stb
  typedef enum int {
    STB_SET_RISE = 0,
    STB_CLR_RISE = 1,
    STB_SET_FALL = 2,
    STB_CLR_FALL = 3
  } stb_idx_e;

  localparam int NUM_STB  = 4;
  localparam int NUM_TRIG = 2;  // 0: rising enables, 1: falling enables
endpackage

// File: rtl/gpio_trig_regs.sv
module gpio_trig_regs
  import gpio_edge_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_STB-1:0]   wr_stb,
  input  logic [NPINS-1:0]     wr_data,
  output logic [NPINS-1:0]     rise_en,
  output logic [NPINS-1:0]     fall_en
);
  logic [NPINS-1:0] trig_q [NUM_TRIG];

  for (genvar g = 0; g < NUM_TRIG; g++) begin : g_trig
    localparam int SET_IDX = 2 * g;
    localparam int CLR_IDX = 2 * g + 1;
    logic [NPINS-1:0] set_mask;
    logic [NPINS-1:0] clr_mask;

    assign set_mask = wr_stb[SET_IDX] ? wr_data : '0;
    assign clr_mask = wr_stb[CLR_IDX] ? wr_data : '0;

    always_ff @(posedge clk) begin
      if (rst) trig_q[g] <= '0;
      else     trig_q[g] <= (trig_q[g] | set_mask) & ~clr_mask;
    end

    // R2
    set_hits_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_stb[SET_IDX] && !wr_stb[CLR_IDX]) |=>
        ((trig_q[g] & $past(wr_data)) == $past(wr_data)));

    // R3 R4
    clr_hits_chk: assert property (@(posedge clk) disable iff (rst)
      wr_stb[CLR_IDX] |=> ((trig_q[g] & $past(wr_data)) == '0));

    // R2 R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!wr_stb[SET_IDX] && !wr_stb[CLR_IDX]) |=> $stable(trig_q[g]));
  end

  assign rise_en = trig_q[0];
  assign fall_en = trig_q[1];
endmodule

// File: rtl/gpio_pin_front.sv
module gpio_pin_front #(
  parameter int NPINS       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pin_in,
  input  logic [NPINS-1:0] out_val,
  input  logic [NPINS-1:0] out_en,
  output logic [NPINS-1:0] level_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [NPINS-1:0] sync_q [SYNC_STAGES];

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) sync_q[s] <= '0;
        else     sync_q[s] <= pin_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) sync_q[s] <= '0;
        else     sync_q[s] <= sync_q[s-1];
      end
    end
  end

  // Observed level is taken after the output-enable mux
  always_comb begin
    for (int i = 0; i < NPINS; i++) begin
      level_o[i] = out_en[i] ? out_val[i] : sync_q[LAST][i];
    end
  end
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] level_i,
  input  logic [NPINS-1:0] rise_en,
  input  logic [NPINS-1:0] fall_en,
  output logic [NPINS-1:0] irq_o,
  output logic [NPINS-1:0] evt_o
);
  logic [NPINS-1:0] prev_q;
  logic [NPINS-1:0] hit;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic went_up;
    logic went_down;
    assign went_up   =  level_i[p] & ~prev_q[p];
    assign went_down = ~level_i[p] &  prev_q[p];
    assign hit[p]    = (rise_en[p] & went_up) | (fall_en[p] & went_down);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      irq_o  <= '0;
      evt_o  <= '0;
    end else begin
      prev_q <= level_i;
      irq_o  <= hit;
      evt_o  <= hit;
    end
  end

  // R5
  no_cfg_no_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_o & ~$past(rise_en | fall_en)) == '0);

  // R6
  fall_only_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_o & $past(~rise_en & fall_en & level_i & ~prev_q)) == '0);

  // R7
  rise_only_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_o & $past(rise_en & ~fall_en & ~level_i & prev_q)) == '0);

  // R11
  evt_match_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o == evt_o);
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpio_edge_pkg::*;
#(
  parameter int NPINS       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_STB-1:0] wr_stb,
  input  logic [NPINS-1:0]   wr_data,
  input  logic [NPINS-1:0]   pin_in,
  input  logic [NPINS-1:0]   out_val,
  input  logic [NPINS-1:0]   out_en,
  output logic [NPINS-1:0]   irq_pulse,
  output logic [NPINS-1:0]   dma_evt
);
  logic [NPINS-1:0] rise_en;
  logic [NPINS-1:0] fall_en;
  logic [NPINS-1:0] level;

  gpio_trig_regs #(.NPINS(NPINS)) i_trig (
    .clk     (clk),
    .rst     (rst),
    .wr_stb  (wr_stb),
    .wr_data (wr_data),
    .rise_en (rise_en),
    .fall_en (fall_en)
  );

  gpio_pin_front #(.NPINS(NPINS), .SYNC_STAGES(SYNC_STAGES)) i_front (
    .clk     (clk),
    .rst     (rst),
    .pin_in  (pin_in),
    .out_val (out_val),
    .out_en  (out_en),
    .level_o (level)
  );

  gpio_edge_det #(.NPINS(NPINS)) i_det (
    .clk     (clk),
    .rst     (rst),
    .level_i (level),
    .rise_en (rise_en),
    .fall_en (fall_en),
    .irq_o   (irq_pulse),
    .evt_o   (dma_evt)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (irq_pulse == '0 && dma_evt == '0));
endmodule

// File: tb/test_gpio_edge_irq.sv
`timescale 1ns/1ps
module test_gpio_edge_irq;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [3:0]   wr_stb = '0;
  logic [N-1:0] wr_data = '0, pin_in = '0, out_val = '0, out_en = '0;
  logic [N-1:0] irq_pulse, dma_evt;

  int    errors = 0;
  int    checks = 0;
  bit    done = 1'b0;
  string tag = "R1";

  // reference model state
  logic [N-1:0] m_s1 = '0, m_s2 = '0, m_prev = '0, m_rise = '0, m_fall = '0, m_irq = '0;

  always #5 clk = ~clk;

  gpio_edge_irq #(.NPINS(N)) i_gpio_edge_irq (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_data(wr_data),
    .pin_in(pin_in), .out_val(out_val), .out_en(out_en),
    .irq_pulse(irq_pulse), .dma_evt(dma_evt)
  );

  function automatic logic [N-1:0] trig_next(logic [N-1:0] cur, logic s, logic c,
                                             logic [N-1:0] d);
    return (cur | (s ? d : '0)) & ~(c ? d : '0);
  endfunction

  function automatic logic [N-1:0] fire(logic [N-1:0] lvl, logic [N-1:0] prv,
                                        logic [N-1:0] r, logic [N-1:0] f);
    return (r & lvl & ~prv) | (f & ~lvl & prv);
  endfunction

  task automatic chk(logic [N-1:0] got, logic [N-1:0] exp, string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  // one clock: model update at the edge, compare at the falling edge
  task automatic step();
    logic [N-1:0] lvl;
    @(posedge clk);
    if (rst) begin
      m_s1 = '0; m_s2 = '0; m_prev = '0; m_rise = '0; m_fall = '0; m_irq = '0;
    end else begin
      lvl    = (out_en & out_val) | (~out_en & m_s2);
      m_irq  = fire(lvl, m_prev, m_rise, m_fall);
      m_prev = lvl;
      m_s2   = m_s1;
      m_s1   = pin_in;
      m_rise = trig_next(m_rise, wr_stb[0], wr_stb[1], wr_data);
      m_fall = trig_next(m_fall, wr_stb[2], wr_stb[3], wr_data);
    end
    @(negedge clk);
    chk(irq_pulse, m_irq, tag);
    chk(dma_evt, m_irq, "R11");
  endtask

  task automatic wr(logic [3:0] stb, logic [N-1:0] d);
    wr_stb = stb; wr_data = d;
    step();
    wr_stb = '0; wr_data = '0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    tag = "R1";
    idle(3);
    chk(irq_pulse, '0, "R1");
    rst = 1'b0;
    pin_in = 8'hFF; idle(4); pin_in = 8'h00; idle(4);   // no enables yet
    chk(irq_pulse, '0, "R1");

    // R2 / R9: rising on pin 0 via external input, latency of three edges
    tag = "R2";
    wr(4'b0001, 8'h01);
    tag = "R9";
    pin_in[0] = 1'b1;
    step(); chk(irq_pulse, '0, "R9");
    step(); chk(irq_pulse, '0, "R9");
    step(); chk(irq_pulse, 8'h01, "R9");
    step(); chk(irq_pulse, '0, "R11");
    // R7: falling edge on rising-only pin is ignored
    tag = "R7";
    pin_in[0] = 1'b0; idle(5);
    chk(irq_pulse, '0, "R7");

    // R6: falling only on pin 1
    tag = "R6";
    wr(4'b0100, 8'h02);
    pin_in[1] = 1'b1; idle(5);
    pin_in[1] = 1'b0; idle(2);
    step(); chk(irq_pulse, 8'h02, "R6");
    idle(2);

    // R8: both edges on pin 2
    tag = "R8";
    wr(4'b0101, 8'h04);
    pin_in[2] = 1'b1; idle(2); step(); chk(irq_pulse, 8'h04, "R8");
    pin_in[2] = 1'b0; idle(2); step(); chk(irq_pulse, 8'h04, "R8");
    idle(2);

    // R3: clear rising on pin 2 only; pin 0 keeps rising enable
    tag = "R3";
    wr(4'b0010, 8'h04);
    pin_in = 8'h05; idle(2); step();
    chk(irq_pulse, 8'h01, "R3");
    pin_in = 8'h00; idle(2); step();
    chk(irq_pulse, 8'h04, "R3");  // falling still enabled on pin 2
    idle(2);

    // R4: set and clear together on pin 2 falling -> cleared
    tag = "R4";
    wr(4'b1100, 8'h04);
    pin_in[2] = 1'b1; idle(4); pin_in[2] = 1'b0; idle(5);
    chk(irq_pulse, '0, "R4");

    // R5: pin 3 never enabled, toggles produce nothing
    tag = "R5";
    for (int i = 0; i < 6; i++) begin pin_in[3] = ~pin_in[3]; idle(2); end
    chk(irq_pulse, '0, "R5");

    // R10: pin 4 driven as output triggers itself
    tag = "R10";
    wr(4'b0101, 8'h10);
    out_en[4] = 1'b1; idle(3);
    out_val[4] = 1'b1; step(); chk(irq_pulse, 8'h10, "R10");
    step(); chk(irq_pulse, '0, "R11");
    out_val[4] = 1'b0; step(); chk(irq_pulse, 8'h10, "R10");

    // R12: enable write on same edge as the edge is judged with old enables
    tag = "R12";
    out_en[5] = 1'b1; idle(2);
    wr_stb = 4'b0001; wr_data = 8'h20; out_val[5] = 1'b1;
    step(); wr_stb = '0; wr_data = '0;
    chk(irq_pulse, '0, "R12");
    out_val[5] = 1'b0; idle(1);
    out_val[5] = 1'b1; step(); chk(irq_pulse, 8'h20, "R12");

    // random phase with model comparison
    tag = "R8";
    for (int i = 0; i < 4000; i++) begin
      pin_in  = N'($urandom);
      out_val = N'($urandom);
      if (($urandom % 8) == 0) out_en = N'($urandom);
      wr_stb  = (($urandom % 4) == 0) ? 4'($urandom) : 4'b0;
      wr_data = N'($urandom);
      if (i == 2000) rst = 1'b1;
      if (i == 2003) rst = 1'b0;
      step();
    end
    wr_stb = '0;
    idle(4);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule